// File: doc/BRIEF.md
# Lane-Parallel Unsigned Saturating Variable Shifter

This block shifts every lane of a 128-bit data vector by a per-lane signed count. The lane width is picked per operation as 8, 16, 32 or 64 bits. Each lane's count comes from the matching lane of a second vector. A positive count shifts left and clamps to all ones when set bits would be lost. A negative count shifts right logically.

Results are registered with one cycle of latency. Each result comes with a flag that says whether any lane clamped. A sticky cumulative flag collects those per-operation flags until a synchronous clear input wipes it. The block suits a vector execution pipe that must report cumulative saturation to a status register held elsewhere.

Top module: `simd_usat_shifter`

## Requirements
- R1: `size_sel` picks the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). Each lane of `a` is paired only with the same-position lane of `b`, and no lane affects another.
- R2: A lane's count is the lowest 8 bits of its `b` lane, read as a two's-complement value from -128 to +127. All other bits of that `b` lane have no effect on the result or the flags.
- R3: A data lane equal to zero gives a zero result lane and does not signal saturation, for any count.
- R4: A count at or below minus the lane width gives a zero result lane with no saturation.
- R5: A count from -1 down to one above minus the lane width gives the lane shifted right by the count's magnitude, with zeros entering at the top.
- R6: A count at or above the lane width, on a nonzero data lane, gives an all-ones lane and signals saturation.
- R7: A count from 0 to lane width minus 1 gives the lane shifted left when no set bit leaves the lane. If any set bit would leave the lane, the result is all ones and saturation is signalled.
- R8: `valid_out`, `result` and `sat` appear one clock after `valid_in`. `sat` is the OR of all lane saturations and is high only together with `valid_out`.
- R9: `qc_sticky` is set by any operation that saturates and stays set until `qc_clear`. A clear in the same cycle as a saturating operation leaves it set.
- R10: While `rst` is high at a clock edge, `valid_out`, `result`, `sat` and `qc_sticky` go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present this cycle |
| size_sel | input | 2 | Lane width select |
| a | input | 128 | Data vector |
| b | input | 128 | Per-lane shift counts |
| qc_clear | input | 1 | Clear the sticky saturation flag |
| valid_out | output | 1 | Result valid |
| result | output | 128 | Shifted vector |
| sat | output | 1 | Some lane of this result saturated |
| qc_sticky | output | 1 | Cumulative saturation flag |

## Verification
The embedded properties assume that `size_sel`, `a` and `b` are stable and known whenever `valid_in` is high. They also assume that `qc_clear` is a clean level sampled at the edge. The bench drives every input at the falling edge, so each input holds for a full period around the sampling edge. Between operations the bench leaves the operands at defined values and never floats them. Random vectors use full 128-bit operands, so the unused high bits of each count lane always carry noise.

// File: rtl/simd_usat_shifter.sv
module simd_usat_shifter #(
  parameter int VEC_W = 128,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [1:0]       size_sel,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             qc_clear,
  output logic             valid_out,
  output logic [VEC_W-1:0] result,
  output logic             sat,
  output logic             qc_sticky
);
  localparam int NSIZE = 4;

  logic [VEC_W-1:0] res_s [NSIZE];
  logic [NSIZE-1:0] sat_s;
  logic             unused_b;

  assign unused_b = ^b;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int W = 8 << s;
    localparam int N = VEC_W / W;
    logic [N-1:0] ov;

    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0]             e, r, shl;
      logic signed [AMT_W-1:0]  amt;
      int                       n;
      logic                     o;

      assign e   = a[i*W +: W];
      assign amt = b[i*W +: AMT_W];
      assign n   = int'(amt);
      assign shl = e << n;

      always_comb begin
        r = '0;
        o = 1'b0;
        if (e == '0) begin
          r = '0;
        end else if (n <= -W) begin
          r = '0;
        end else if (n < 0) begin
          r = e >> (-n);
        end else if (n >= W) begin
          r = '1;
          o = 1'b1;
        end else if ((shl >> n) != e) begin
          r = '1;
          o = 1'b1;
        end else begin
          r = shl;
        end
      end

      assign res_s[s][i*W +: W] = r;
      assign ov[i] = o;
    end

    assign sat_s[s] = |ov;
  end

  logic op_sat;
  assign op_sat = valid_in & sat_s[size_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      result    <= '0;
      sat       <= 1'b0;
      qc_sticky <= 1'b0;
    end else begin
      valid_out <= valid_in;
      sat       <= op_sat;
      if (valid_in) result <= res_s[size_sel];
      qc_sticky <= (qc_sticky & ~qc_clear) | op_sat;
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  a_r8_sat_only_valid: assert property (@(posedge clk) disable iff (rst)
    sat |-> valid_out);
  a_r3_zero_data: assert property (@(posedge clk) disable iff (rst)
    (valid_in && a == '0) |=> (result == '0 && !sat));
  a_r9_sat_sets_sticky: assert property (@(posedge clk) disable iff (rst)
    sat |-> qc_sticky);
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (qc_sticky && !qc_clear) |=> qc_sticky);
  a_r9_clear_wins_idle: assert property (@(posedge clk) disable iff (rst)
    (qc_clear && !valid_in) |=> !qc_sticky);
endmodule

// File: tb/sim_simd_usat_shifter.sv
module sim_simd_usat_shifter;
  logic clk = 0, rst = 1, valid_in = 0, qc_clear = 0;
  logic [1:0] size_sel = 0;
  logic [127:0] a = '0, b = '0, result;
  logic valid_out, sat, qc_sticky;

  int errors = 0, checks = 0;
  bit exp_sticky = 0;

  logic [127:0] q_res[$];
  bit q_sat[$];
  bit q_stk[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  simd_usat_shifter u0 (.clk(clk), .rst(rst), .valid_in(valid_in), .size_sel(size_sel),
    .a(a), .b(b), .qc_clear(qc_clear), .valid_out(valid_out), .result(result),
    .sat(sat), .qc_sticky(qc_sticky));

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model
  task automatic ref_op(input int sz, input logic [127:0] va, input logic [127:0] vb,
                        output logic [127:0] res, output bit s);
    int w = 8 << sz;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    res = '0; s = 0;
    for (int i = 0; i < 128 / w; i++) begin
      logic [63:0] e = (va >> (i * w)) & mask;
      logic [63:0] r = '0, sh;
      int n = int'($signed(vb[i*w +: 8]));
      if (e == 0 || n <= -w) r = 0;
      else if (n < 0) r = e >> (-n);
      else if (n >= w) begin r = mask; s = 1; end
      else begin
        sh = (e << n) & mask;
        if ((sh >> n) != e) begin r = mask; s = 1; end
        else r = sh;
      end
      res = res | ({64'd0, r} << (i * w));
    end
  endtask

  function automatic logic [127:0] rep(int sz, logic [63:0] v);
    int w = 8 << sz;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [127:0] x = '0;
    for (int i = 0; i < 128 / w; i++) x = x | ({64'd0, v & mask} << (i * w));
    return x;
  endfunction

  task automatic drive(string tag, int sz, logic [127:0] va, logic [127:0] vb, bit clr);
    logic [127:0] er; bit es;
    @(negedge clk);
    ref_op(sz, va, vb, er, es);
    exp_sticky = (clr ? 1'b0 : exp_sticky) | es;
    q_res.push_back(er); q_sat.push_back(es); q_stk.push_back(exp_sticky); q_tag.push_back(tag);
    valid_in = 1; size_sel = 2'(sz); a = va; b = vb; qc_clear = clr;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      valid_in = 0; qc_clear = 0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      if (q_res.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected valid_out act=1 exp=0");
      end else begin
        string t = q_tag.pop_front();
        chk({t, " result"}, result, q_res.pop_front());
        chk({t, " sat R8"}, {127'd0, sat}, {127'd0, q_sat.pop_front()});
        chk({t, " sticky R9"}, {127'd0, qc_sticky}, {127'd0, q_stk.pop_front()});
      end
    end
  end

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 valid_out", {127'd0, valid_out}, 0);
    chk("R10 result", result, 0);
    chk("R10 sat", {127'd0, sat}, 0);
    chk("R10 sticky", {127'd0, qc_sticky}, 0);
    rst = 0;

    for (int sz = 0; sz < 4; sz++) begin
      int w = 8 << sz;
      int amts[8] = '{0, w - 1, w, 127, -1, -w, -128, 1 - w};
      logic [63:0] dats[4] = '{64'd0, '1, 64'd1, 64'h8421_0F3C_5A5A_1234};
      for (int k = 0; k < 8; k++)
        for (int d = 0; d < 4; d++) begin
          logic [63:0] bv = {{56{1'b0}}, 8'(amts[k])};
          string tg = (d == 0) ? "R3" : (amts[k] <= -w) ? "R4" : (amts[k] < 0) ? "R5" :
                      (amts[k] >= w) ? "R6" : "R7";
          drive({tg, " directed R1"}, sz, rep(sz, dats[d]), rep(sz, bv), 0);
        end
      // R2: high bits of count lane are noise
      drive("R2 high count bits ignored", sz, rep(sz, 64'h3), rep(sz, 64'hFFFF_FFFF_FFFF_FF01), 0);
    end
    idle(3);

    // R9: clear alone, then clear with saturating op, then clear with clean op
    @(negedge clk); qc_clear = 1; valid_in = 0; exp_sticky = 0;
    @(negedge clk); qc_clear = 0;
    chk("R9 clear idle", {127'd0, qc_sticky}, 0);
    drive("R9 clear+sat", 0, rep(0, 64'hFF), rep(0, 64'h01), 1);
    drive("R9 clear+nosat", 0, rep(0, 64'h01), rep(0, 64'h01), 1);
    idle(3);

    for (int k = 0; k < 400; k++) begin
      logic [127:0] ra = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] rb = {$urandom, $urandom, $urandom, $urandom};
      if (k % 3 == 0) ra = ra >> ($urandom % 128);
      drive("R1 R2 random", int'($urandom % 4), ra, rb, ($urandom % 16) == 0);
    end
    idle(4);
    if (q_res.size() != 0) begin
      errors++; checks++;
      $display("FAIL R8 missing results act=%0d exp=0", q_res.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule